// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that lets an external controller reach a 256-entry, 8-bit register array through a register pointer. The 7-bit device address is the fixed pattern 110000 with a strap input as its lowest bit.

In a write, the first byte after the address byte loads the pointer. Every byte after that is stored at the pointer, and the pointer then steps forward. A read takes no address byte of its own. It returns data from wherever the pointer currently sits. To read a chosen location, a controller first sends a short write that carries only the register byte, then issues a repeated START and reads.

On the chip side the block offers a plain local port. It can read any entry combinationally and write any entry. Bit 0 of register 51h is brought out as a standby control. SDA is handled as open drain: the block only outputs an enable that pulls the line low.

Top module: `i2c_reg_target`

## Requirements
- R1: The target answers the address byte {1,1,0,0,0,0,addrStrap} followed by R/W (R/W=0 write, R/W=1 read). It ACKs that byte by pulling SDA low (sdaOe=1) during the ninth clock. With addrStrap low, C0h writes and C1h reads.
- R2: An address byte with any other 7-bit address gets no ACK. SDA is left undriven and all following bytes are ignored until the next START or STOP. No register and no pointer value changes.
- R3: In a write, the first byte after the address byte loads the pointer and is ACKed.
- R4: Each further byte of a write is stored at the pointer, ACKed, and advances the pointer, so successive bytes land at successive addresses.
- R5: A read sends the byte at the pointer MSB first and advances the pointer by one per byte sent. A controller ACK (SDA low on the ninth clock) makes the target send the next byte. A NACK makes it release SDA and send nothing more.
- R6: The pointer is 00h after reset, keeps its value from one transaction to the next, and wraps from FFh to 00h.
- R7: A write carrying only a register byte, followed by a repeated START and a read address byte, makes the read start at that register.
- R8: The standby output equals bit 0 of register 51h. It is 0 after reset, becomes 1 when 01h is written there, and becomes 0 when 00h is written there, whether the write comes from I2C or from the local port.
- R9: A START or STOP in the middle of a byte abandons that byte: no register is written. A START always restarts address decoding.
- R10: lclRdata shows the register selected by lclAddr. A cycle with lclWe high stores lclWdata there. All registers reset to 00h.
- R11: The target changes sdaOe only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | I2C clock line level |
| sdaIn | input | 1 | I2C data line level |
| sdaOe | output | 1 | High pulls SDA low |
| addrStrap | input | 1 | Lowest bit of the device address |
| lclAddr | input | 8 | Local port register select |
| lclWe | input | 1 | Local port write strobe |
| lclWdata | input | 8 | Local port write data |
| lclRdata | output | 8 | Register contents at lclAddr |
| standby | output | 1 | Bit 0 of register 51h |

## Verification
The bench writes two bytes starting at FFh and expects them at FFh and 00h. A pointer that failed to wrap, or that overflowed into a wider counter, would put the second byte in the wrong place. It reads with no address byte after earlier reads ended in NACK, so a pointer that advanced one step too many or too few returns a neighbour's value. It aborts a byte halfway with a STOP and with a repeated START, which catches a design that stores a half-assembled byte. It also sends foreign addresses and flips the strap, which catches a target that ACKs the wrong device or keeps writing after a miss.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftIn;    // sample SDA into the shift register
    logic loadPtr;    // pointer <= received byte
    logic writeMem;   // register[pointer] <= received byte, pointer++
    logic driveAck;   // pull SDA low for the acknowledge bit
    logic releaseSda; // let SDA float
    logic loadTx;     // fetch register[pointer], drive its MSB, pointer++
    logic shiftTx;    // drive the next transmit bit
  } dpStrobe_t;

  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK} phase_t;
  typedef enum logic [1:0] {BK_ADDR, BK_PTR, BK_DATA} byteKind_t;
endpackage

// File: rtl/i2c_reg_sync.sv
module i2c_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-1:0], sdaIn};
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclPrev  = sclPipe[STAGES];
  assign sdaPrev  = sdaPipe[STAGES];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [5:0] DEV_HI = 6'b110000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaLvl,
  input  logic [7:0] rxByte,
  input  logic       addrStrap,
  output dpStrobe_t  strobe,
  output logic       idle
);
  phase_t    phase;
  byteKind_t kind;
  logic [3:0] bitCnt;
  logic isRead, moreRd, addrHit, byteEnd;

  assign addrHit = (rxByte[7:1] == {DEV_HI, addrStrap});
  assign byteEnd = sclFall && (bitCnt == 4'd8);
  assign idle    = (phase == PH_IDLE);

  always_comb begin
    strobe = '0;
    if (startDet || stopDet) begin
      strobe.releaseSda = 1'b1;
    end else begin
      case (phase)
        PH_RX: begin
          strobe.shiftIn = sclRise && (bitCnt < 4'd8);
          if (byteEnd) begin
            case (kind)
              BK_ADDR: strobe.driveAck = addrHit;
              BK_PTR: begin
                strobe.loadPtr  = 1'b1;
                strobe.driveAck = 1'b1;
              end
              default: begin
                strobe.writeMem = 1'b1;
                strobe.driveAck = 1'b1;
              end
            endcase
          end
        end
        PH_RXACK: if (sclFall) begin
          if (isRead) strobe.loadTx = 1'b1;
          else        strobe.releaseSda = 1'b1;
        end
        PH_TX: if (sclFall) begin
          if (bitCnt == 4'd8) strobe.releaseSda = 1'b1;
          else                strobe.shiftTx = 1'b1;
        end
        PH_TXACK: strobe.loadTx = sclFall && moreRd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      kind   <= BK_ADDR;
      bitCnt <= '0;
      isRead <= 1'b0;
      moreRd <= 1'b0;
    end else if (startDet) begin
      phase  <= PH_RX;
      kind   <= BK_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_RX: begin
          if (sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteEnd) begin
            if (kind == BK_ADDR && !addrHit) phase <= PH_IDLE;
            else phase <= PH_RXACK;
            if (kind == BK_ADDR) isRead <= rxByte[0];
          end
        end
        PH_RXACK: if (sclFall) begin
          bitCnt <= '0;
          if (isRead) phase <= PH_TX;
          else begin
            phase <= PH_RX;
            kind  <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
          end
        end
        PH_TX: begin
          if (sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteEnd) phase <= PH_TXACK;
        end
        PH_TXACK: begin
          if (sclRise) moreRd <= !sdaLvl;
          if (sclFall) begin
            bitCnt <= '0;
            phase  <= moreRd ? PH_TX : PH_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_dp.sv
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  STBY_ADDR = 8'h51
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaLvl,
  input  logic [ADDR_W-1:0] lclAddr,
  input  logic              lclWe,
  input  logic [7:0]        lclWdata,
  output logic [7:0]        lclRdata,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaOe,
  output logic              standby
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] regs [DEPTH];
  logic [7:0] shiftReg;
  logic [7:0] curByte;

  assign curByte  = regs[ptr];
  assign rxByte   = shiftReg;
  assign lclRdata = regs[lclAddr];
  assign standby  = regs[STBY_ADDR[ADDR_W-1:0]][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (strobe.writeMem) begin
      regs[ptr] <= shiftReg;
    end else if (lclWe) begin
      regs[lclAddr] <= lclWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ptr      <= '0;
      sdaOe    <= 1'b0;
    end else begin
      if (strobe.shiftIn)      shiftReg <= {shiftReg[6:0], sdaLvl};
      else if (strobe.loadTx)  shiftReg <= curByte;
      else if (strobe.shiftTx) shiftReg <= {shiftReg[6:0], 1'b0};

      if (strobe.loadPtr) ptr <= shiftReg[ADDR_W-1:0];
      else if (strobe.writeMem || strobe.loadTx) ptr <= ptr + 1'b1;

      if (strobe.loadTx)          sdaOe <= ~curByte[7];
      else if (strobe.shiftTx)    sdaOe <= ~shiftReg[6];
      else if (strobe.driveAck)   sdaOe <= 1'b1;
      else if (strobe.releaseSda) sdaOe <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] STBY_ADDR   = 8'h51,
  parameter logic [5:0] DEV_HI      = 6'b110000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              addrStrap,
  input  logic [ADDR_W-1:0] lclAddr,
  input  logic              lclWe,
  input  logic [7:0]        lclWdata,
  output logic [7:0]        lclRdata,
  output logic              standby
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet, ctrlIdle;
  logic [7:0] rxByte;
  logic [ADDR_W-1:0] ptr;
  dpStrobe_t strobe;

  i2c_reg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_reg_ctrl #(.DEV_HI(DEV_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .addrStrap(addrStrap), .strobe(strobe), .idle(ctrlIdle)
  );

  i2c_reg_dp #(.ADDR_W(ADDR_W), .STBY_ADDR(STBY_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaLvl(sdaLvl),
    .lclAddr(lclAddr), .lclWe(lclWe), .lclWdata(lclWdata), .lclRdata(lclRdata),
    .rxByte(rxByte), .ptr(ptr), .sdaOe(sdaOe), .standby(standby)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_reg_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] STBY_ADDR = 8'h51
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              standby,
  input logic              sclLvl,
  input logic              startDet,
  input logic              stopDet,
  input logic              ctrlIdle,
  input logic [ADDR_W-1:0] ptr,
  input logic [ADDR_W-1:0] lclAddr,
  input logic              lclWe,
  input dpStrobe_t         strobe
);
  a_r11_sda_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (!$past(sclLvl) || $past(startDet || stopDet)));

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> ($past(strobe.loadPtr) || ptr == $past(ptr) + 1'b1));

  a_r8_standby_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(standby) |->
      ($past(strobe.writeMem && ptr == STBY_ADDR[ADDR_W-1:0]) ||
       $past(lclWe && lclAddr == STBY_ADDR[ADDR_W-1:0])));

  a_r4_write_acked: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeMem |=> sdaOe);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIdle |-> !sdaOe);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.ADDR_W(ADDR_W), .STBY_ADDR(STBY_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .standby(standby), .sclLvl(sclLvl),
  .startDet(startDet), .stopDet(stopDet), .ctrlIdle(ctrlIdle), .ptr(ptr),
  .lclAddr(lclAddr), .lclWe(lclWe), .strobe(strobe)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sdaDrv = 1'b1, addrStrap = 1'b0;
  logic [7:0] lclAddr = '0, lclWdata = '0;
  logic lclWe = 1'b0;
  logic sdaOe, standby, sdaLine;
  logic [7:0] lclRdata;

  int nChecks = 0, nFail = 0;
  int sclViol = 0, quietViol = 0;
  logic quietWatch = 1'b0, prevOe = 1'b0;
  logic [7:0] model [256];
  logic [7:0] ptrModel = '0;
  int unsigned seedDummy;

  always #5 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaOe;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrStrap(addrStrap), .lclAddr(lclAddr), .lclWe(lclWe), .lclWdata(lclWdata),
    .lclRdata(lclRdata), .standby(standby)
  );

  // R11 and R2 monitors
  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && scl === 1'b1) sclViol++;
    if (quietWatch && sdaOe === 1'b1) quietViol++;
    prevOe = sdaOe;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] devByte(input logic rd);
    return {6'b110000, addrStrap, rd};
  endfunction

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic busStart(); sdaDrv = 1'b0; waitQ(); scl = 1'b0; waitQ(); endtask
  task automatic busRestart();
    sdaDrv = 1'b1; waitQ(); scl = 1'b1; waitQ(); sdaDrv = 1'b0; waitQ(); scl = 1'b0; waitQ();
  endtask
  task automatic busStop(); sdaDrv = 1'b0; waitQ(); scl = 1'b1; waitQ(); sdaDrv = 1'b1; waitQ(); endtask
  task automatic sendBit(input logic b);
    sdaDrv = b; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0; waitQ();
  endtask
  task automatic recvBit(output logic b);
    sdaDrv = 1'b1; waitQ(); scl = 1'b1; waitQ(); b = sdaLine; waitQ(); scl = 1'b0; waitQ();
  endtask
  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(a);
    acked = !a;
  endtask
  task automatic recvByte(output logic [7:0] v, input logic more);
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    sendBit(!more);
  endtask

  task automatic writeRegs(input logic [7:0] p, input int n, input logic [7:0] d [4], input string tag);
    logic a;
    busStart();
    sendByte(devByte(1'b0), a); chk({tag, " R1 addr ack"}, a, 1);
    sendByte(p, a);             chk({tag, " R3 ptr ack"}, a, 1);
    ptrModel = p;
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], a);        chk({tag, " R4 data ack"}, a, 1);
      model[ptrModel] = d[i];
      ptrModel++;
    end
    busStop();
  endtask

  task automatic readBody(input int n, input string tag);
    logic a;
    logic [7:0] v;
    sendByte(devByte(1'b1), a); chk({tag, " R1 read addr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(v, i < n - 1);
      chk({tag, " R5 read data"}, v, model[ptrModel]);
      ptrModel++;
    end
    busStop();
    chk({tag, " R5 released"}, sdaOe, 0);
  endtask

  task automatic readHere(input int n, input string tag);
    busStart(); readBody(n, tag);
  endtask

  task automatic readAt(input logic [7:0] p, input int n, input string tag);
    logic a;
    busStart();
    sendByte(devByte(1'b0), a); chk({tag, " R7 addr ack"}, a, 1);
    sendByte(p, a);             chk({tag, " R7 ptr ack"}, a, 1);
    ptrModel = p;
    busRestart();
    readBody(n, tag);
  endtask

  task automatic lclCheck(input logic [7:0] addr, input string tag);
    lclAddr = addr; @(negedge clk);
    chk(tag, lclRdata, model[addr]);
  endtask

  task automatic lclWrite(input logic [7:0] addr, input logic [7:0] v);
    lclAddr = addr; lclWdata = v; lclWe = 1'b1; @(negedge clk);
    lclWe = 1'b0; model[addr] = v;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R0 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d [4];
    seedDummy = $urandom(32'h5eed);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state (R8, R10)
    chk("reset sdaOe", sdaOe, 0);
    chk("reset R8 standby", standby, 0);
    lclCheck(8'h00, "reset R10 reg00");
    lclCheck(8'hA7, "reset R10 regA7");

    // R6: pointer starts at 00h
    lclWrite(8'h00, 8'h3C);
    lclWrite(8'h01, 8'hC3);
    readHere(2, "R6 reset pointer");

    // R1, R3, R4: two data bytes at 10h
    d = '{8'hAA, 8'hBB, 8'h00, 8'h00};
    writeRegs(8'h10, 2, d, "basic write");
    lclCheck(8'h10, "R4 reg10");
    lclCheck(8'h11, "R4 reg11");

    // R10 + R6 persistence: continue at 12h without an address byte
    lclWrite(8'h12, 8'h5A);
    lclWrite(8'h13, 8'h77);
    readHere(2, "R6 persist");
    readHere(1, "R6 persist after nack");

    // R7: dummy write then repeated START
    readAt(8'h10, 2, "R7 dummy write");

    // R6: wrap FFh -> 00h
    d = '{8'h11, 8'h22, 8'h00, 8'h00};
    writeRegs(8'hFF, 2, d, "R6 wrap");
    lclCheck(8'hFF, "R6 regFF");
    lclCheck(8'h00, "R6 reg00 wrapped");
    readAt(8'hFF, 2, "R6 read wrap");

    // R8: standby control
    d = '{8'h01, 8'h00, 8'h00, 8'h00};
    writeRegs(8'h51, 1, d, "R8 set");
    chk("R8 standby set", standby, 1);
    d = '{8'h00, 8'h00, 8'h00, 8'h00};
    writeRegs(8'h51, 1, d, "R8 clear");
    chk("R8 standby clear", standby, 0);
    lclWrite(8'h51, 8'h03);
    chk("R8 local set", standby, 1);
    lclWrite(8'h51, 8'h00);
    chk("R8 local clear", standby, 0);

    // R2: foreign address ignored
    readAt(8'h40, 1, "R2 prep");
    busStart();
    quietWatch = 1'b1;
    sendByte(8'hC4, a); chk("R2 foreign addr nack", a, 0);
    sendByte(8'h20, a); chk("R2 ptr byte nack", a, 0);
    sendByte(8'h99, a); chk("R2 data byte nack", a, 0);
    quietWatch = 1'b0;
    busStop();
    chk("R2 sda never driven", quietViol, 0);
    lclCheck(8'h20, "R2 reg20 unchanged");
    readHere(1, "R2 pointer unchanged");

    // R1: strap selects address bit
    addrStrap = 1'b1;
    busStart(); sendByte(8'hC0, a); busStop();
    chk("R1 strap high C0 nack", a, 0);
    d = '{8'h6E, 8'h00, 8'h00, 8'h00};
    writeRegs(8'h60, 1, d, "R1 strap high C2");
    lclCheck(8'h60, "R1 strap reg60");
    addrStrap = 1'b0;

    // R9: STOP in mid byte
    busStart();
    sendByte(devByte(1'b0), a); sendByte(8'h30, a);
    ptrModel = 8'h30;
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    lclCheck(8'h30, "R9 stop abort reg30");
    readHere(1, "R9 pointer after stop abort");
    // R9: repeated START in mid byte
    busStart();
    sendByte(devByte(1'b0), a);
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    busRestart();
    sendByte(devByte(1'b0), a); chk("R9 restart addr ack", a, 1);
    sendByte(8'h40, a);
    sendByte(8'h66, a);
    model[8'h40] = 8'h66;
    busStop();
    lclCheck(8'h40, "R9 restart write reg40");

    // Random write/read-back (R4, R5, R7)
    for (int it = 0; it < 25; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
      writeRegs(p, n, d, "rand R4");
      readAt(p, n, "rand R5");
    end

    chk("R11 sda only changes with scl low", sclViol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule